// File: doc/BRIEF.md
# Four-Input Look-Up Logic Element Chain

This block is a short chain of configurable logic elements. Each element keeps a sixteen-bit truth table in configuration flip-flops. Its four data inputs form an index that picks exactly one stored bit. Each element also has an optional output register, a cascade path that folds its result into a neighbour's result with AND or OR, and a carry path that lets adjacent elements form a ripple adder. The table and the mode bits of every element are loaded through one serial configuration port. They keep their values until the next load.

The wrapper connects `NUM_LE` elements in a line. The cascade and carry inputs of element 0 come from the ports. Each later element takes the cascade and carry outputs of the element before it. The last element drives the chain's cascade and carry outputs. With every element in arithmetic mode the chain is an n-bit adder. With the cascade enabled it is a wide AND or a wide OR of up to `4*NUM_LE` inputs.

Configuration is not complete until a full load has shifted in. Until then, every output of the block is held at 0 and no element register captures a value.

Top module: `le_chain`

## Requirements
- R1: In table mode, element i drives `le_out[i]` from table bit number `{d3,d2,d1,d0}`, where d0 is `data_in[4i]` and d3 is `data_in[4i+3]`. The output is combinational when the registered-output bit is 0. As an example, the table 16'h8421 makes the element a 2-bit equality compare of `{d3,d2}` against `{d1,d0}`.
- R2: The serial load works as follows. While `cfg_load` is 1, each rising clock shifts in `cfg_din`. After exactly `20*NUM_LE` shifts, the k-th bit sent sits at configuration bit k. Element i owns configuration bits `[20i+19:20i]`, laid out as follows:
  - bits 15..0: table bits 15..0
  - bit 16: registered output
  - bit 17: cascade enable
  - bit 18: cascade OR (0 selects AND)
  - bit 19: arithmetic mode

  While `cfg_load` is 0, `cfg_din` has no effect and the configuration holds.
- R3: `cfg_done` resets to 0 and clears on the clock after `cfg_load` is sampled high. It is set on the first clock that samples `cfg_load` low after at least `20*NUM_LE` consecutive shifts, and it stays set until the next load. A load cut short leaves it at 0. While `cfg_done` is 0, `le_out`, `casc_out` and `carry_out` are 0.
- R4: With cascade enabled, an element's result is its own table output combined with its cascade input by AND (cascade OR bit = 0) or by OR (cascade OR bit = 1). With cascade disabled, the result equals its own table output. The cascade output of each element is its result.
- R5: In arithmetic mode, a is d0, b is d1 and the carry input is c. The sum is table bit `{0,a,b,c}` and the carry output is table bit `{1,a,b,c}`; d2 and d3 are ignored. Table 16'hE896 makes a full adder. Outside arithmetic mode, the carry output equals the carry input.
- R6: With the registered-output bit set, `le_out[i]` shows a register that captures the element's result on a rising clock when `ce` is 1 and `cfg_done` is 1. Otherwise the register holds. An asynchronous low `rst_n` clears this register and all configuration state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| ce | input | 1 | Clock enable of the element registers |
| cfg_load | input | 1 | Serial configuration shift enable |
| cfg_din | input | 1 | Serial configuration data |
| cfg_done | output | 1 | Configuration complete; gates normal operation |
| data_in | input | 4*NUM_LE | Four data inputs per element |
| casc_in | input | 1 | Cascade input of element 0 |
| carry_in | input | 1 | Carry input of element 0 |
| le_out | output | NUM_LE | Output of each element |
| casc_out | output | 1 | Cascade output of the last element |
| carry_out | output | 1 | Carry output of the last element |

## Verification
The assertions assume that `rst_n` is the only asynchronous input. They also assume that `ce`, `cfg_load` and `cfg_din` settle between clock edges, because the register-hold and configuration-hold properties compare values across single edges. The bench changes every input on the falling clock edge. It always sends exactly `20*NUM_LE` bits in a full load and ends each load by dropping `cfg_load` for at least one edge. Every interruption of a load is deliberate and is followed by a complete reload before any output is checked.

// File: rtl/le_pkg.sv
package le_pkg;
    localparam int LUT_K  = 4;
    localparam int TBL_N  = 1 << LUT_K;
    localparam int MODE_W = 4;
    localparam int CFG_W  = TBL_N + MODE_W;

    // configuration word of one element, LSB = table bit 0
    typedef struct packed {
        logic             arith;
        logic             casc_or;
        logic             casc_en;
        logic             reg_sel;
        logic [TBL_N-1:0] tbl;
    } le_cfg_t;
endpackage

// File: rtl/le_cfg_loader.sv
module le_cfg_loader #(
    parameter int TOTAL = 80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic             cfg_din,
    output logic [TOTAL-1:0] cfg_bits,
    output logic             done
);
    localparam int CW = $clog2(TOTAL + 1);
    localparam logic [CW-1:0] FULL = CW'(TOTAL);

    typedef struct packed {
        logic [TOTAL-1:0] bits;
        logic [CW-1:0]    cnt;
        logic             done;
    } ld_st_t;

    ld_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_load) begin
            st_d.bits = {cfg_din, st_q.bits[TOTAL-1:1]};
            st_d.cnt  = (st_q.cnt == FULL) ? FULL : st_q.cnt + 1'b1;
            st_d.done = 1'b0;
        end else begin
            st_d.done = st_q.done | (st_q.cnt == FULL);
            st_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_bits = st_q.bits;
    assign done     = st_q.done;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> $stable(st_q.bits)); // R2
    AST_DONE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> !st_q.done); // R3
    AST_DONE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && !cfg_load) |=> st_q.done); // R3
endmodule

// File: rtl/le_cell.sv
module le_cell
    import le_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  le_cfg_t          cfg,
    input  logic [LUT_K-1:0] din,
    input  logic             casc_in,
    input  logic             carry_in,
    output logic             le_o,
    output logic             casc_o,
    output logic             carry_o
);
    typedef struct packed {
        logic q;
    } cell_st_t;

    cell_st_t st_d, st_q;
    logic     lut_o, sum_o, cy_o, res;
    logic [2:0] ah;

    always_comb begin
        lut_o = cfg.tbl[din];
        ah    = {din[0], din[1], carry_in};
        sum_o = cfg.tbl[{1'b0, ah}];
        cy_o  = cfg.tbl[{1'b1, ah}];
        res   = cfg.arith ? sum_o : lut_o;
        if (cfg.casc_en) casc_o = cfg.casc_or ? (res | casc_in) : (res & casc_in);
        else             casc_o = res;
        carry_o = cfg.arith ? cy_o : carry_in;
        st_d    = st_q;
        if (cap_en) st_d.q = casc_o;
        le_o = cfg.reg_sel ? st_q.q : casc_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(st_q.q)); // R6
    AST_REG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (st_q.q == $past(casc_o))); // R6
endmodule

// File: rtl/le_chain.sv
module le_chain
    import le_pkg::*;
#(
    parameter int NUM_LE = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ce,
    input  logic                cfg_load,
    input  logic                cfg_din,
    output logic                cfg_done,
    input  logic [4*NUM_LE-1:0] data_in,
    input  logic                casc_in,
    input  logic                carry_in,
    output logic [NUM_LE-1:0]   le_out,
    output logic                casc_out,
    output logic                carry_out
);
    localparam int TOTAL = NUM_LE * CFG_W;

    logic [TOTAL-1:0]  cfg_bits;
    logic              done;
    logic [NUM_LE:0]   casc_w, carry_w;
    logic [NUM_LE-1:0] raw_out;

    le_cfg_loader #(.TOTAL(TOTAL)) u_loader (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_load (cfg_load),
        .cfg_din  (cfg_din),
        .cfg_bits (cfg_bits),
        .done     (done)
    );

    assign casc_w[0]  = casc_in;
    assign carry_w[0] = carry_in;

    for (genvar i = 0; i < NUM_LE; i++) begin : g_le
        le_cfg_t cfg_i;
        assign cfg_i = le_cfg_t'(cfg_bits[i*CFG_W +: CFG_W]);
        le_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .cap_en   (ce & done),
            .cfg      (cfg_i),
            .din      (data_in[i*LUT_K +: LUT_K]),
            .casc_in  (casc_w[i]),
            .carry_in (carry_w[i]),
            .le_o     (raw_out[i]),
            .casc_o   (casc_w[i+1]),
            .carry_o  (carry_w[i+1])
        );
    end

    assign cfg_done  = done;
    assign le_out    = done ? raw_out : '0;
    assign casc_out  = done & casc_w[NUM_LE];
    assign carry_out = done & carry_w[NUM_LE];
endmodule

// File: tb/le_chain_tb.sv
module le_chain_tb;
    localparam int N     = 4;
    localparam int TOTAL = N * 20;

    logic clk = 0, rst_n = 0, ce = 0, cfg_load = 0, cfg_din = 0;
    logic casc_in = 0, carry_in = 0;
    logic [4*N-1:0] data_in = '0;
    logic [N-1:0] le_out;
    logic cfg_done, casc_out, carry_out;
    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    le_chain #(.NUM_LE(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce(ce), .cfg_load(cfg_load), .cfg_din(cfg_din),
        .cfg_done(cfg_done), .data_in(data_in), .casc_in(casc_in), .carry_in(carry_in),
        .le_out(le_out), .casc_out(casc_out), .carry_out(carry_out)
    );

    typedef struct packed {
        logic [3:0] a;
        logic [3:0] b;
        logic       ci;
        logic [4:0] exp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{4'h0, 4'h0, 1'b0, 5'd0},  '{4'h3, 4'h5, 1'b0, 5'd8},
        '{4'hF, 4'h1, 1'b0, 5'd16}, '{4'hF, 4'hF, 1'b1, 5'd31},
        '{4'h9, 4'h6, 1'b1, 5'd16}, '{4'hA, 4'h5, 1'b0, 5'd15},
        '{4'h7, 4'h7, 1'b1, 5'd15}, '{4'h8, 4'h8, 1'b0, 5'd16}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [TOTAL-1:0] mk(input logic [15:0] tbl, input logic arith,
                                            input logic c_or, input logic c_en, input logic rsel);
        logic [19:0] w = {arith, c_or, c_en, rsel, tbl};
        return {N{w}};
    endfunction

    task automatic load(input logic [TOTAL-1:0] v);
        for (int k = 0; k < TOTAL; k++) begin
            @(negedge clk); cfg_load = 1; cfg_din = v[k];
        end
        @(negedge clk); cfg_load = 0; cfg_din = 0;
        @(negedge clk);
        chk("R3 done after full load", cfg_done, 1);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        carry_in = 1; casc_in = 1; data_in = '1; ce = 1;
        #5;
        chk("R3 reset cfg_done", cfg_done, 0);
        chk("R3 reset le_out", le_out, 0);
        chk("R3 reset casc_out", casc_out, 0);
        chk("R3 reset carry_out", carry_out, 0);
        @(negedge clk); rst_n = 1;
        @(negedge clk); #2;
        chk("R3 unconfigured outputs held", {le_out, casc_out, carry_out}, 0);

        // comparator, table mode, combinational
        load(mk(16'h8421, 0, 0, 0, 0));
        for (int idx = 0; idx < 16; idx++) begin
            logic e;
            @(negedge clk);
            data_in = {N{idx[3:0]}}; carry_in = idx[0];
            e = (idx[3:2] == idx[1:0]);
            #2;
            chk($sformatf("R1 compare idx %0d", idx), le_out, {N{e}});
            chk("R4 cascade off passes own result", casc_out, e);
            chk("R5 carry pass-through", carry_out, idx[0]);
        end

        // stray serial data while not loading
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); cfg_din = k[0];
        end
        @(negedge clk); cfg_din = 0; data_in = {N{4'h5}}; #2;
        chk("R2 config held idx 5", le_out, 4'hF);
        @(negedge clk); data_in = {N{4'h6}}; #2;
        chk("R2 config held idx 6", le_out, 4'h0);

        // adder vector table
        load(mk(16'hE896, 1, 0, 0, 0));
        for (int v = 0; v < 8; v++) begin
            logic [4*N-1:0] d;
            for (int i = 0; i < N; i++) d[4*i +: 4] = {2'b11, VECS[v].b[i], VECS[v].a[i]};
            @(negedge clk); data_in = d; carry_in = VECS[v].ci; #2;
            chk($sformatf("R5 sum vec %0d", v), le_out, VECS[v].exp[3:0]);
            chk($sformatf("R5 carry vec %0d", v), carry_out, VECS[v].exp[4]);
            chk("R4 cascade off in adder", casc_out, VECS[v].exp[3]);
        end

        // wide AND
        load(mk(16'h8000, 0, 0, 1, 0));
        @(negedge clk); data_in = '1; casc_in = 1; #2;
        chk("R4 wide AND all ones", casc_out, 1);
        chk("R4 first element partial", le_out[0], 1);
        @(negedge clk); data_in = ~(16'h1 << 9); #2;
        chk("R4 wide AND one zero", casc_out, 0);
        @(negedge clk); data_in = '1; casc_in = 0; #2;
        chk("R4 wide AND cascade in low", casc_out, 0);

        // wide OR
        load(mk(16'hFFFE, 0, 1, 1, 0));
        @(negedge clk); data_in = '0; casc_in = 0; #2;
        chk("R4 wide OR all zero", casc_out, 0);
        @(negedge clk); data_in = 16'h1 << 13; #2;
        chk("R4 wide OR one set", casc_out, 1);
        @(negedge clk); data_in = '0; casc_in = 1; #2;
        chk("R4 wide OR cascade in high", casc_out, 1);

        // partial reload drops done and gates outputs
        for (int k = 0; k < 10; k++) begin
            @(negedge clk); cfg_load = 1; cfg_din = 1;
        end
        @(negedge clk); cfg_load = 0; #2;
        chk("R3 done cleared by load", cfg_done, 0);
        chk("R3 outputs gated", {le_out, casc_out}, 0);
        @(negedge clk); @(negedge clk); #2;
        chk("R3 short load stays not done", cfg_done, 0);

        // registered comparator
        load(mk(16'h8421, 0, 0, 0, 1));
        @(negedge clk); ce = 1; data_in = {N{4'h5}};
        @(negedge clk); #2;
        chk("R6 register captured", le_out, 4'hF);
        ce = 0; data_in = {N{4'h1}};
        @(negedge clk); @(negedge clk); #2;
        chk("R6 register held with ce low", le_out, 4'hF);
        ce = 1;
        @(negedge clk); #2;
        chk("R6 register recaptured", le_out, 4'h0);
        data_in = {N{4'hA}};
        @(negedge clk); #2;
        chk("R6 register captured again", le_out, 4'hF);
        #3 rst_n = 0; #1;
        chk("R6 async clear output", le_out, 0);
        chk("R6 async clear done", cfg_done, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule